// File: doc/BRIEF.md
# Configuration Stream Length Extractor

This block watches the opening bytes of a configuration image as they are read back from serial flash and works out how many bytes the stored image occupies. Bytes come in one at a time over a valid/ready stream and are already in the correct bit order. The scan skips fill bytes of value 0xFF until it finds the sync byte 0x6A. It then discards a fixed four-byte field and collects a 32-bit bit count sent low byte first. That count is rounded up to whole bytes.

Software or a boot sequencer pulses `start_i` and then streams the head of the flash into the block. When the scan ends, the block raises `done_o` for one cycle. At that point `known_o` says whether any length was found, and `len_bytes_o` carries the length, or zero when it is unknown. Both stay put until the next start.

The stream rules are as follows. A byte moves only on a cycle where `in_valid_i` and `in_ready_o` are both high. The source may drop `in_valid_i` on any cycle and the scan simply waits. The block drops `in_ready_o` once the scan has ended, and keeps it low until the next start. It also holds it low during the cycle in which `start_i` is high. The source must keep a byte and its valid flag steady until that byte is taken.

Top module: `hdr_len_scan`

## Requirements
- R1: After reset, and in the cycle after any `start_i` pulse, `done_o`, `known_o` and `len_bytes_o` are all zero. A start pulse abandons a scan in progress and begins a new one at byte index 0. `in_ready_o` is low while `start_i` is high, so no byte is taken in that cycle.
- R2: A byte is consumed exactly when `in_valid_i` and `in_ready_o` are high at a clock edge. Cycles with `in_valid_i` low change nothing. `in_ready_o` stays low from the end of a scan until the next start.
- R3: A byte equal to 0xFF at a search position is fill. It is skipped and the search goes on at the next byte.
- R4: A byte equal to 0x6A at a search position is the sync byte. The four bytes after it are discarded whatever their values, including 0x6A and 0xFF.
- R5: The four bytes after the discarded field form a 32-bit bit count. The first of them is bits 7:0 and the last is bits 31:24.
- R6: The reported length is the bit count divided by 8, rounded up, computed without wrap-around. The range is 0 to 2^29, on a 30-bit `len_bytes_o`.
- R7: Any byte other than 0xFF or 0x6A at a search position ends the scan. `known_o` is 1 exactly when a bit count was captured earlier in the scan.
- R8: After a bit count has been captured, the search resumes at the next byte. Fill is skipped there, a later sync byte replaces the length with the new count, and any other byte ends the scan with the latest length.
- R9: The window is 128 bytes, and search positions are byte indices 0 to 119. A sync byte at index 119 is accepted and its count ends at index 127. When the search reaches index 120 or beyond, the scan ends without taking another byte.
- R10: `done_o` is a single-cycle pulse. It comes in the cycle after the ending byte is consumed, or one cycle after the search reaches the window limit. `known_o` and `len_bytes_o` keep their values until the next start.
- R11: When `known_o` is 0, `len_bytes_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new scan |
| in_valid_i | input | 1 | Stream byte valid |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| in_data_i | input | 8 | Stream byte, bit order already corrected |
| done_o | output | 1 | One-cycle pulse when the scan has ended |
| known_o | output | 1 | A length was found in this scan |
| len_bytes_o | output | 30 | Configuration length in bytes, zero when unknown |

## Verification
A wrong search index or a wrong field-byte counter shows up at the ports as a wrong number of bytes taken before `done_o`. The bench counts every handshake, so the error is caught on the same scan that exposes it. A shift or round-up fault in the count path appears as a wrong `len_bytes_o` at the `done_o` pulse. A missed or repeated end-of-scan shows up as `in_ready_o` staying high after `done_o`, or as `done_o` lasting more than one cycle. Each of these is visible within one cycle of the end of the scan.

// File: rtl/hdr_len_pkg.sv
package hdr_len_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_FIELD
  } scan_st_e;

  typedef enum logic [1:0] {
    BC_PAD,
    BC_SYNC,
    BC_OTHER
  } byte_cls_e;

endpackage

// File: rtl/hdr_byte_class.sv
module hdr_byte_class
  import hdr_len_pkg::*;
#(
  parameter logic [7:0] PAD_BYTE  = 8'hFF,
  parameter logic [7:0] SYNC_BYTE = 8'h6A
) (
  input  logic [7:0] byte_i,
  output byte_cls_e  cls_o
);

  // The sync test comes first, so the sync byte wins if the two values ever match.
  always_comb begin
    if (byte_i == SYNC_BYTE) begin
      cls_o = BC_SYNC;
    end else if (byte_i == PAD_BYTE) begin
      cls_o = BC_PAD;
    end else begin
      cls_o = BC_OTHER;
    end
  end

endmodule

// File: rtl/hdr_scan_ctrl.sv
module hdr_scan_ctrl
  import hdr_len_pkg::*;
#(
  parameter int WINDOW      = 128,
  parameter int SKIP_LEN    = 4,
  parameter int COUNT_BYTES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      in_valid_i,
  input  byte_cls_e cls_i,
  output logic      in_ready_o,
  output logic      shift_o,
  output logic      capture_o,
  output logic      finish_o
);

  localparam int TAIL  = SKIP_LEN + COUNT_BYTES;
  localparam int LIMIT = WINDOW - TAIL;
  localparam int POS_W = $clog2(WINDOW + 1);
  localparam int FC_W  = (TAIL > 1) ? $clog2(TAIL) : 1;

  scan_st_e          state_q;
  logic [POS_W-1:0]  pos_q;
  logic [FC_W-1:0]   fcnt_q;

  logic search_open;
  logic in_field;
  logic accept;
  logic field_last;

  assign search_open = (state_q == ST_SEARCH) && (pos_q < POS_W'(LIMIT));
  assign in_field    = (state_q == ST_FIELD);
  assign in_ready_o  = !start_i && (search_open || in_field);
  assign accept      = in_valid_i && in_ready_o;
  assign field_last  = (fcnt_q == FC_W'(TAIL - 1));

  // Bytes in the trailing field never reach the fill or sync decision.
  assign shift_o   = accept && in_field && (fcnt_q >= FC_W'(SKIP_LEN));
  assign capture_o = accept && in_field && field_last;
  assign finish_o  = !start_i && (state_q == ST_SEARCH) &&
                     ((pos_q >= POS_W'(LIMIT)) || (accept && (cls_i == BC_OTHER)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      fcnt_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      fcnt_q  <= '0;
    end else begin
      if (accept) begin
        pos_q <= pos_q + POS_W'(1);
      end
      unique case (state_q)
        ST_SEARCH: begin
          if (finish_o) begin
            state_q <= ST_IDLE;
          end else if (accept && (cls_i == BC_SYNC)) begin
            state_q <= ST_FIELD;
            fcnt_q  <= '0;
          end
        end
        ST_FIELD: begin
          if (accept) begin
            if (field_last) begin
              state_q <= ST_SEARCH;
              fcnt_q  <= '0;
            end else begin
              fcnt_q <= fcnt_q + FC_W'(1);
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/hdr_count_acc.sv
module hdr_count_acc #(
  parameter int COUNT_BYTES = 4,
  localparam int CNT_W = 8 * COUNT_BYTES,
  localparam int LEN_W = CNT_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic             capture_i,
  input  logic             finish_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic             known_o,
  output logic [LEN_W-1:0] len_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic [LEN_W-1:0] hold_q;
  logic [LEN_W-1:0] conv;
  logic             seen_q;

  // Low byte arrives first: each new byte enters at the top and slides down.
  generate
    if (COUNT_BYTES == 1) begin : g_one
      assign cnt_next = byte_i;
    end else begin : g_many
      assign cnt_next = {byte_i, cnt_q[CNT_W-1:8]};
    end
  endgenerate

  // Round up: whole bytes plus one when any of the low three bits is set.
  assign conv = {1'b0, cnt_next[CNT_W-1:3]} + LEN_W'(|cnt_next[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      hold_q  <= '0;
      seen_q  <= 1'b0;
      done_o  <= 1'b0;
      known_o <= 1'b0;
      len_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q   <= '0;
        hold_q  <= '0;
        seen_q  <= 1'b0;
        known_o <= 1'b0;
        len_o   <= '0;
      end else begin
        if (shift_i) begin
          cnt_q <= cnt_next;
        end
        if (capture_i) begin
          hold_q <= conv;
          seen_q <= 1'b1;
        end
        if (finish_i) begin
          done_o  <= 1'b1;
          known_o <= seen_q;
          len_o   <= hold_q;
        end
      end
    end
  end

endmodule

// File: rtl/hdr_len_scan.sv
module hdr_len_scan
  import hdr_len_pkg::*;
#(
  parameter int         WINDOW      = 128,
  parameter int         SKIP_LEN    = 4,
  parameter int         COUNT_BYTES = 4,
  parameter logic [7:0] PAD_BYTE    = 8'hFF,
  parameter logic [7:0] SYNC_BYTE   = 8'h6A,
  localparam int        LEN_W       = 8 * COUNT_BYTES - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  output logic             done_o,
  output logic             known_o,
  output logic [LEN_W-1:0] len_bytes_o
);

  byte_cls_e cls;
  logic      shift;
  logic      capture;
  logic      finish;

  hdr_byte_class #(
    .PAD_BYTE (PAD_BYTE),
    .SYNC_BYTE(SYNC_BYTE)
  ) u_class (
    .byte_i(in_data_i),
    .cls_o (cls)
  );

  hdr_scan_ctrl #(
    .WINDOW     (WINDOW),
    .SKIP_LEN   (SKIP_LEN),
    .COUNT_BYTES(COUNT_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .in_valid_i(in_valid_i),
    .cls_i     (cls),
    .in_ready_o(in_ready_o),
    .shift_o   (shift),
    .capture_o (capture),
    .finish_o  (finish)
  );

  hdr_count_acc #(
    .COUNT_BYTES(COUNT_BYTES)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .shift_i  (shift),
    .capture_i(capture),
    .finish_i (finish),
    .byte_i   (in_data_i),
    .done_o   (done_o),
    .known_o  (known_o),
    .len_o    (len_bytes_o)
  );

endmodule

// File: rtl/hdr_len_scan_chk.sv
module hdr_len_scan_chk #(
  parameter int WINDOW = 128,
  parameter int LEN_W  = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             done_o,
  input logic             known_o,
  input logic [LEN_W-1:0] len_bytes_o
);

  int unsigned taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 0;
    end else if (start_i) begin
      taken_q <= 0;
    end else if (in_valid_i && in_ready_o) begin
      taken_q <= taken_q + 1;
    end
  end

  // R1: no byte is taken while a start is requested
  p_start_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !in_ready_o);

  // R1: results are cleared right after a start
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !known_o && (len_bytes_o == '0)));

  // R2: the stream is closed when the scan has ended
  p_closed_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready_o);

  // R9: never more bytes taken than the window holds
  p_window_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= WINDOW);

  // R10: completion lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: results move only at completion or right after a start
  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(start_i)) |-> ($stable(known_o) && $stable(len_bytes_o)));

  // R11: an unknown length reads as zero
  p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !known_o |-> (len_bytes_o == '0));

endmodule

bind hdr_len_scan hdr_len_scan_chk #(
  .WINDOW(WINDOW),
  .LEN_W (LEN_W)
) u_chk (.*);

// File: tb/test_hdr_len_scan.sv
module test_hdr_len_scan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        in_valid_i;
  logic [7:0]  in_data_i;
  logic        in_ready_o;
  logic        done_o;
  logic        known_o;
  logic [29:0] len_bytes_o;

  int          checks   = 0;
  int          failures = 0;
  logic [7:0]  buf_q [0:127];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  hdr_len_scan i_hdr_len_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .done_o     (done_o),
    .known_o    (known_o),
    .len_bytes_o(len_bytes_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 128; i++) buf_q[i] = v;
  endtask

  task automatic put_bits(input int at, input logic [31:0] v);
    buf_q[at]   = v[7:0];
    buf_q[at+1] = v[15:8];
    buf_q[at+2] = v[23:16];
    buf_q[at+3] = v[31:24];
  endtask

  // Expected result straight from the requirements
  task automatic model(output bit k, output longint unsigned l, output int cons);
    int p = 0;
    logic [31:0] bits;
    k = 0; l = 0; cons = -1;
    while (p < 120) begin
      if (buf_q[p] == 8'h6A) begin
        bits = {buf_q[p+8], buf_q[p+7], buf_q[p+6], buf_q[p+5]};
        l = (longint'(bits) + 7) >> 3;
        k = 1;
        p = p + 9;
      end else if (buf_q[p] == 8'hFF) begin
        p = p + 1;
      end else begin
        cons = p + 1;
        break;
      end
    end
    if (cons < 0) cons = p;
  endtask

  task automatic start_pulse();
    @(negedge clk);
    start_i    = 1'b1;
    in_valid_i = 1'b1;
    in_data_i  = 8'h00;
    #1;
    chk(in_ready_o == 1'b0, "R1", "ready while start high", in_ready_o, 0);
    @(negedge clk);
    start_i    = 1'b0;
    in_valid_i = 1'b0;
  endtask

  task automatic run_partial(input int n);
    int idx = 0;
    bit take;
    start_pulse();
    while (idx < n) begin
      in_valid_i = 1'b1;
      in_data_i  = buf_q[idx];
      #1 take = in_valid_i && in_ready_o;
      @(negedge clk);
      if (take) idx++;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic run_scan(input bit stall, input string req);
    bit ek, got, take, rk;
    longint unsigned el;
    int ec, idx, cyc;
    logic [29:0] rl;
    model(ek, el, ec);
    start_pulse();
    chk(!done_o && !known_o && len_bytes_o == 0, "R1", "cleared after start",
        {known_o, len_bytes_o}, 0);
    idx = 0; cyc = 0; got = 0; rk = 0; rl = '0;
    while (!got && cyc < 3000) begin
      if (done_o) begin
        got = 1; rk = known_o; rl = len_bytes_o; in_valid_i = 1'b0;
      end else begin
        in_valid_i = (idx < 128) && (!stall || lfsr[0]);
        if (stall) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_data_i = (idx < 128) ? buf_q[idx[6:0]] : 8'h00;
        #1 take = in_valid_i && in_ready_o;
        @(negedge clk);
        if (take) idx++;
        cyc++;
      end
    end
    chk(got, "R10", "done seen", got, 1);
    chk(rk == ek, req, "known", rk, ek);
    chk(longint'(rl) == el, req, "length", rl, el);
    chk(idx == ec, req, "bytes consumed", idx, ec);
    chk(rk || rl == 0, "R11", "unknown reads zero", rl, 0);
    @(negedge clk);
    chk(!done_o, "R10", "done one cycle", done_o, 0);
    chk(!in_ready_o, "R2", "closed after done", in_ready_o, 0);
    chk(known_o == rk && len_bytes_o == rl, "R10", "result held", len_bytes_o, rl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; in_valid_i = 1'b0; in_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !known_o && len_bytes_o == 0 && !in_ready_o, "R1", "reset state",
        {done_o, known_o, in_ready_o}, 0);

    // R3 R4 R7: every value in the first search position
    for (int v = 0; v < 256; v++) begin
      fill(8'h00);
      buf_q[0] = v[7:0];
      run_scan(v[0], "R7");
    end

    // R5 R9 R8 R2: sync at every search position, with and without stalls
    for (int p = 0; p < 120; p++) begin
      fill(8'hFF);
      buf_q[p] = 8'h6A;
      for (int s = 1; s <= 4; s++) buf_q[p+s] = 8'(p * 7 + s);
      if (p % 3 == 0) buf_q[p+1] = 8'h6A;
      if (p % 5 == 0) buf_q[p+2] = 8'hFF;
      put_bits(p + 5, 32'(p) * 32'h9E3779B9 + 32'(p));
      if ((p % 2 == 0) && (p + 9 < 128)) buf_q[p+9] = 8'h12;
      run_scan(p[1], "R9");
    end

    // R6: round-up edges
    begin
      logic [31:0] vals [0:8];
      vals = '{32'd0, 32'd1, 32'd7, 32'd8, 32'd9, 32'd16, 32'hFFFF_FFF8,
               32'hFFFF_FFF9, 32'hFFFF_FFFF};
      for (int i = 0; i < 9; i++) begin
        fill(8'h00);
        buf_q[0] = 8'hFF;
        buf_q[1] = 8'h6A;
        put_bits(6, vals[i]);
        run_scan(1'b0, "R6");
      end
    end

    // R8: later sync replaces the length; back-to-back syncs
    fill(8'hFF);
    buf_q[3] = 8'h6A; put_bits(8, 32'd1000);
    buf_q[20] = 8'h6A; put_bits(25, 32'd77);
    buf_q[40] = 8'h3C;
    run_scan(1'b0, "R8");
    fill(8'h00);
    buf_q[0] = 8'h6A; put_bits(5, 32'd64);
    buf_q[9] = 8'h6A; put_bits(14, 32'd65);
    buf_q[18] = 8'hFF;
    run_scan(1'b1, "R8");

    // R9 R11: all fill exhausts the window
    fill(8'hFF);
    run_scan(1'b0, "R9");
    run_scan(1'b1, "R11");

    // R3: fill then a terminator, nothing captured
    fill(8'hFF);
    buf_q[50] = 8'h01;
    run_scan(1'b0, "R3");

    // R1: restart in the middle of the field, then a fresh scan
    fill(8'hFF);
    buf_q[1] = 8'h6A;
    run_partial(4);
    fill(8'h00);
    buf_q[0] = 8'h6A; put_bits(5, 32'd24);
    run_scan(1'b0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule